// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits behind a small 32-bit memory-mapped register interface spanning a 4 KB window. Software sets each pin's direction. It reads and writes pin data through an alias region in which the word address itself is the bit mask. This lets a single store touch chosen pins without a read-modify-write. Pins configured as inputs are sampled into the data register every clock. Pins not driven as outputs present a logic high on the output bus.

A bank of sixteen 8-bit configuration registers holds pad and interrupt settings for the surrounding pad ring. The block only stores these values and does not act on them, apart from the interrupt enable. External edge or level detection logic reports events on a strobe input. The block keeps them in a raw status register that software can clear. It gates them with the enable register and merges them onto one interrupt line. A fixed set of twelve identification bytes sits at the top of the window.

Bus reads are combinational and valid in the same cycle as the select. Writes take effect on the next rising clock edge. An access to an offset that maps to nothing raises a one-cycle error pulse on the edge after the access.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the data, direction, raw status and all sixteen configuration registers read zero, `pin_out` is 8'hFF, and `irq` and `bus_err` are low.
- R2: A read at an offset below 0x400 returns the data register ANDed with address bits [9:2].
- R3: A write at an offset below 0x400 updates only the data bits that are set both in address bits [9:2] and in the direction register (bit = 1 means output). Output bits outside that set keep their value.
- R4: Each `pin_out` bit equals the data bit when its direction bit is 1, and equals 1 when its direction bit is 0.
- R5: On every clock, each data bit whose direction bit is 0 takes the value of the matching `pin_in` bit. Bits whose direction bit is 1 ignore `pin_in`.
- R6: The direction register (0x400) and the configuration registers store bits [7:0] of the write data and read back zero-extended. The configuration registers sit at 0x404, 0x408, 0x40C, 0x410 (interrupt enable), 0x420 and the eleven words 0x500 to 0x528.
- R7: The twelve words from 0xFD0 to 0xFFC read, in ascending address order, the bytes 00,00,00,00,61,10,04,00,0D,F0,05,B1. Writes to these words have no effect.
- R8: A 1 on an `evt_set` bit sets the matching raw status bit, read at 0x414. A write to 0x41C clears the raw bits at the positions of the ones in the write data. A set and a clear of the same bit in the same cycle leave it set. Offset 0x41C reads zero.
- R9: Offset 0x418 reads raw status AND the interrupt enable at 0x410. `irq` is high exactly when that value is non-zero. Writes to 0x414 and 0x418 have no effect.
- R10: An access to any other offset reads zero and changes no state. `bus_err` is high for the one cycle after each such access and low after every mapped access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Unmapped-access pulse, one cycle after the access |
| pin_in | input | 8 | External input pin levels |
| pin_out | output | 8 | Output pin levels, high where not driven |
| evt_set | input | 8 | Interrupt event strobes from the external detector |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Masked writes are swept over all 256 address masks under four direction patterns: all inputs, all outputs, and two mixed patterns. The all-inputs case shows that the direction gate blocks every write. The all-outputs case isolates the address mask. The mixed cases catch a design that applies only one of the two gates. Masked reads are swept over all 256 masks with fixed data, and all 256 input levels are applied under a half-output direction, which shows that sampling reaches input bits only. The interrupt enable is swept over all 256 values with a fixed raw pattern, which separates AND from OR gating and proves that each enable bit affects only its own lane of `irq`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int GPIO_W  = 8;
  localparam int N_CFG   = 16;
  localparam int CFG_IEN = 3;
  localparam int N_ID    = 12;

  typedef enum logic [2:0] {
    RG_DATA, RG_DIR, RG_CFG, RG_RAW, RG_MIS, RG_ICLR, RG_ID, RG_NONE
  } rgn_e;

  function automatic int cfg_slot(input logic [11:0] a);
    logic [9:0] w;
    w = a[11:2];
    case (w)
      10'h101: return 0;
      10'h102: return 1;
      10'h103: return 2;
      10'h104: return 3;
      10'h108: return 4;
      default: begin
        if (w >= 10'h140 && w <= 10'h14A) return 5 + int'(w - 10'h140);
        return -1;
      end
    endcase
  endfunction

  function automatic rgn_e classify(input logic [11:0] a);
    logic [9:0] w;
    w = a[11:2];
    if (w < 10'h100)            return RG_DATA;
    else if (w == 10'h100)      return RG_DIR;
    else if (cfg_slot(a) >= 0)  return RG_CFG;
    else if (w == 10'h105)      return RG_RAW;
    else if (w == 10'h106)      return RG_MIS;
    else if (w == 10'h107)      return RG_ICLR;
    else if (w >= 10'h3F4)      return RG_ID;
    else                        return RG_NONE;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd4:    return 8'h61;
      4'd5:    return 8'h10;
      4'd6:    return 8'h04;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [GPIO_W-1:0] merge_bits(input logic [GPIO_W-1:0] old_v,
                                                   input logic [GPIO_W-1:0] new_v,
                                                   input logic [GPIO_W-1:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

  function automatic logic [GPIO_W-1:0] pad_level(input logic [GPIO_W-1:0] dat,
                                                  input logic [GPIO_W-1:0] dir);
    return merge_bits({GPIO_W{1'b1}}, dat, dir);
  endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int W = GPIO_W,
  parameter int N = N_CFG,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [W-1:0]  wr_val,
  output logic [W-1:0]  regs_o [N]
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs_o[g] <= '0;
      else if (wr_en && wr_slot == SW'(g))  regs_o[g] <= wr_val;
    end
  end

endmodule

// File: rtl/gpio_data_unit.sv
module gpio_data_unit
  import gpio_port_pkg::*;
#(
  parameter int W = GPIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_val,
  input  logic         dir_we,
  input  logic [W-1:0] dir_val,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] wr_bits_o,
  output logic [W-1:0] pin_out
);

  logic [W-1:0] data_nx;

  assign wr_bits_o = wr_en ? (wr_mask & dir_o) : '0;

  always_comb begin
    data_nx = merge_bits(data_o, wr_val, wr_bits_o);
    data_nx = merge_bits(data_nx, pin_in, ~dir_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      dir_o  <= '0;
    end else begin
      data_o <= data_nx;
      if (dir_we) dir_o <= dir_val;
    end
  end

  assign pin_out = pad_level(data_o, dir_o);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_port_pkg::*;
#(
  parameter int W = GPIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] enable,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= (raw_o & ~clr_bits) | evt_set;
  end

  assign masked_o = raw_o & enable;
  assign irq      = |masked_o;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W      = GPIO_W,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NCFG   = N_CFG,
  localparam int SW    = $clog2(NCFG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  input  logic [W-1:0]      evt_set,
  output logic              irq
);

  rgn_e         rgn;
  logic [SW-1:0] slot;
  logic         wr_acc, unmapped_hit;
  logic [W-1:0] addr_mask, data_q, dir_q, wr_bits, raw_q, mis_q, clr_bits, ien_q;
  logic [W-1:0] cfg_q [NCFG];
  logic [3:0]   id_idx;

  assign rgn          = classify(bus_addr);
  assign slot         = SW'(cfg_slot(bus_addr));
  assign wr_acc       = bus_sel & bus_wr;
  assign unmapped_hit = bus_sel & (rgn == RG_NONE);
  assign addr_mask    = bus_addr[W+1:2];
  assign id_idx       = 4'(bus_addr[ADDR_W-1:2] - 10'h3F4);
  assign clr_bits     = (wr_acc && rgn == RG_ICLR) ? bus_wdata[W-1:0] : '0;
  assign ien_q        = cfg_q[CFG_IEN];

  gpio_data_unit #(.W(W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_acc && rgn == RG_DATA), .wr_mask(addr_mask), .wr_val(bus_wdata[W-1:0]),
    .dir_we(wr_acc && rgn == RG_DIR), .dir_val(bus_wdata[W-1:0]),
    .pin_in(pin_in), .data_o(data_q), .dir_o(dir_q), .wr_bits_o(wr_bits),
    .pin_out(pin_out)
  );

  gpio_cfg_bank #(.W(W), .N(NCFG)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_acc && rgn == RG_CFG), .wr_slot(slot), .wr_val(bus_wdata[W-1:0]),
    .regs_o(cfg_q)
  );

  gpio_irq_unit #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .evt_set(evt_set), .clr_bits(clr_bits), .enable(ien_q),
    .raw_o(raw_q), .masked_o(mis_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rgn)
        RG_DATA: bus_rdata[W-1:0] = data_q & addr_mask;
        RG_DIR:  bus_rdata[W-1:0] = dir_q;
        RG_CFG:  bus_rdata[W-1:0] = cfg_q[slot];
        RG_RAW:  bus_rdata[W-1:0] = raw_q;
        RG_MIS:  bus_rdata[W-1:0] = mis_q;
        RG_ID:   bus_rdata[7:0]   = id_byte(id_idx);
        default: bus_rdata        = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= unmapped_hit;
  end

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic [W-1:0]      pin_in,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      evt_set,
  input logic              irq,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      wr_bits,
  input logic [W-1:0]      raw_q,
  input logic [W-1:0]      clr_bits,
  input logic [W-1:0]      ien_q,
  input logic              unmapped_hit
);

  a_r4_undriven_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out | dir_q) == {W{1'b1}});

  a_r3_write_confined: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_bits)) == '0));

  a_r5_input_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q & ~$past(dir_q)) == ($past(pin_in) & ~$past(dir_q))));

  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(clr_bits) & ~$past(evt_set)) == '0));

  a_r9_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q != '0));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(unmapped_hit));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_hit && !bus_wr) |-> (bus_rdata == '0));

endmodule

bind gpio_port_ctrl gpio_port_checker #(.W(W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out), .evt_set(evt_set),
  .irq(irq), .data_q(data_q), .dir_q(dir_q), .wr_bits(wr_bits), .raw_q(raw_q),
  .clr_bits(clr_bits), .ien_q(ien_q), .unmapped_hit(unmapped_hit)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err, irq;
  logic [7:0]  pin_in = 8'h00, pin_out, evt_set = 8'h00;

  int checks = 0, errors = 0;
  logic [7:0] m_data = 8'h00, m_dir = 8'h00;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out),
    .evt_set(evt_set), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  function automatic logic [11:0] cfg_addr(input int i);
    logic [11:0] low [5] = '{12'h404, 12'h408, 12'h40C, 12'h410, 12'h420};
    return (i < 5) ? low[i] : 12'(12'h500 + 4 * (i - 5));
  endfunction

  function automatic logic [7:0] id_exp(input int i);
    logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                           8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [7:0] cfg_val(input int i);
    return 8'(i * 29 + 8'h4B);
  endfunction

  // every data bit that is an input follows the pins after one edge
  function automatic logic [7:0] sampled();
    return (m_data & m_dir) | (pin_in & ~m_dir);
  endfunction

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] dirs [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", {24'h0, pin_out}, 32'hFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 bus_err", {31'h0, bus_err}, 32'h0);
    rst_n = 1;
    rd(12'h400, rv); chk("R1 dir", rv, 0);
    rd(12'h3FC, rv); chk("R1 data", rv, 0);
    rd(12'h414, rv); chk("R1 raw", rv, 0);
    for (int i = 0; i < 16; i++) begin
      rd(cfg_addr(i), rv); chk("R1 cfg", rv, 0);
    end

    // R3 R4 R5 masked write sweep under four direction patterns
    pin_in = 8'h5A;
    for (int d = 0; d < 4; d++) begin
      @(negedge clk); m_data = sampled();
      wr(12'h400, {24'hFFFFFF, dirs[d]}); m_dir = dirs[d];
      rd(12'h400, rv); chk("R6 dir readback", rv, {24'h0, dirs[d]});
      m_data = sampled();
      for (int m = 0; m < 256; m++) begin
        logic [7:0] v, en;
        v  = 8'(m * 37 + d * 11);
        en = 8'(m) & m_dir;
        wr(12'(m << 2), {24'hC3C3C3, v});
        m_data = (m_data & ~en) | (v & en);
        rd(12'h3FC, rv); chk("R3 masked write", rv, {24'h0, m_data});
        chk("R4 pin_out", {24'h0, pin_out}, {24'h0, (m_data & m_dir) | ~m_dir});
      end
    end

    // R2 read mask sweep
    wr(12'h400, 32'hFF); m_dir = 8'hFF;
    wr(12'h3FC, 32'hA5); m_data = 8'hA5;
    for (int m = 0; m < 256; m++) begin
      rd(12'(m << 2), rv); chk("R2 masked read", rv, {24'h0, 8'hA5 & 8'(m)});
    end

    // R5 input sampling only on input bits
    wr(12'h400, 32'h0F); m_dir = 8'h0F;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pin_in = 8'(p);
      rd(12'h3FC, rv); chk("R5 capture", rv, {24'h0, (8'hA5 & 8'h0F) | (8'(p) & 8'hF0)});
    end
    m_data = sampled();

    // R6 configuration storage
    for (int i = 0; i < 16; i++) wr(cfg_addr(i), {24'hABCDE7, cfg_val(i)});
    for (int i = 0; i < 16; i++) begin
      rd(cfg_addr(i), rv); chk("R6 cfg", rv, {24'h0, cfg_val(i)});
    end

    // R7 identification bytes, writes ignored
    wr(12'hFD0, 32'hFF); wr(12'hFE0, 32'h12);
    for (int i = 0; i < 12; i++) begin
      rd(12'(12'hFD0 + 4 * i), rv); chk("R7 id", rv, {24'h0, id_exp(i)});
    end

    // R8 raw status set, clear, set wins
    wr(12'h410, 32'h00);
    @(negedge clk); evt_set = 8'h5A; @(negedge clk); evt_set = 8'h00;
    rd(12'h414, rv); chk("R8 raw set", rv, 32'h5A);
    chk("R9 irq off when disabled", {31'h0, irq}, 0);
    wr(12'h41C, 32'h42);
    rd(12'h414, rv); chk("R8 raw clear", rv, 32'h18);
    rd(12'h41C, rv); chk("R8 clear reads zero", rv, 0);
    @(negedge clk); evt_set = 8'h01; bus_sel = 1; bus_wr = 1; bus_addr = 12'h41C; bus_wdata = 32'h01;
    @(negedge clk); evt_set = 8'h00; bus_sel = 0; bus_wr = 0;
    rd(12'h414, rv); chk("R8 set wins", rv, 32'h19);
    @(negedge clk); evt_set = 8'h42; @(negedge clk); evt_set = 8'h00;

    // R9 enable sweep against raw 5B, read-only status writes ignored
    wr(12'h414, 32'h00); wr(12'h418, 32'hFF);
    rd(12'h414, rv); chk("R9 raw write ignored", rv, 32'h5B);
    for (int m = 0; m < 256; m++) begin
      wr(12'h410, m);
      rd(12'h418, rv); chk("R9 masked status", rv, {24'h0, 8'h5B & 8'(m)});
      chk("R9 irq", {31'h0, irq}, {31'h0, |(8'h5B & 8'(m))});
    end
    chk("R10 no err on mapped", {31'h0, bus_err}, 0);

    // R10 unmapped accesses
    begin
      logic [11:0] bad [4] = '{12'h42C, 12'h530, 12'h800, 12'hFCC};
      for (int i = 0; i < 4; i++) begin
        rd(bad[i], rv); chk("R10 unmapped reads zero", rv, 0);
        chk("R10 err pulse", {31'h0, bus_err}, 1);
        @(negedge clk); chk("R10 err one cycle", {31'h0, bus_err}, 0);
        wr(bad[i], 32'hFFFFFFFF);
        chk("R10 err on write", {31'h0, bus_err}, 1);
      end
    end
    wr(12'h400, 32'hFF); m_dir = 8'hFF; m_data = sampled();
    rd(12'h3FC, rv); chk("R10 data intact", rv, {24'h0, m_data});
    rd(12'h414, rv); chk("R10 raw intact", rv, 32'h5B);
    for (int i = 0; i < 16; i++) begin
      rd(cfg_addr(i), rv);
      chk("R10 cfg intact", rv, (i == 3) ? 32'hFF : {24'h0, cfg_val(i)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule